// File: doc/BRIEF.md
# Slot-Table Time-Division Arbiter

This block shares one resource among up to eight requester classes by walking a programmable schedule of 16 turns. Each turn holds a 4-bit class code. When the turn pointer rests on a turn whose class is asking for service, that class receives a one-hot grant. The grant stays up until the owner signals completion or an optional countdown runs out. Turns that hold the idle code, a code above 7, or a class that is not asking are passed over at one turn per cycle.

Software loads the schedule and the countdown through a narrow write port. Two 32-bit words carry eight turns each. A third word carries an 8-bit countdown preset and an active-low timer enable. The current turn number is brought out so that neighbouring logic can see where the rotation stands.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is applied and after it is released, grantOut is 0 and slotIdx is 0. Every turn holds the idle code 2. The timer word resets to preset 0 with the disable bit set, so no request is granted until the schedule is written.
- R2: A write with cfgSel=0 loads turns 0..7 and a write with cfgSel=1 loads turns 8..15. Turn k takes cfgWrData[4*(k mod 8)+3 : 4*(k mod 8)]. cfgSel=2 loads the timer word, and cfgSel=3 changes nothing.
- R3: Codes 0..7 name the class whose grant bit is that code, with code 2 as the exception: code 2 is idle and grants nobody. Codes 8..15 grant nobody. An idle or out-of-range turn is passed over in one cycle, whatever reqIn holds.
- R4: When no grant is active and the current turn's class has its reqIn bit high at a clock edge, that edge raises the class's grant bit. slotIdx stays on that turn for as long as the grant lasts.
- R5: When no grant is active and the current turn's class is not requesting, slotIdx advances by one at each clock edge.
- R6: A grant is held until grantDone is high at a clock edge. That edge clears the grant and moves slotIdx up by one, and no new grant starts on the same edge.
- R7: In the timer word, bits [7:0] hold the preset and bit 16 is the disable bit, so 0 enables the timer. With the timer enabled, a grant that sees no grantDone lasts exactly preset+1 cycles and then ends as in R6. With the timer disabled, the grant is held for as long as needed.
- R8: At most one bit of grantOut is high in any cycle.
- R9: slotIdx wraps from 15 to 0.
- R10: grantDone has no effect while no grant is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Word select: 0 low turns, 1 high turns, 2 timer |
| cfgWrData | input | 32 | Configuration write data |
| reqIn | input | 8 | Request line per class code 0..7 |
| grantDone | input | 1 | Owner signals its grant has finished |
| grantOut | output | 8 | One-hot grant, bit index equals class code |
| slotIdx | output | 4 | Current turn number |

## Verification
The schedule is tried with a single request aligned to a chosen turn in the low word and in the high word. This shows that field placement and the code-to-grant-bit mapping are right. Requests with all bits high on idle and reserved turns separate a correct skip from a decoder that truncates the code and grants the wrong class. A request raised one turn late tells a skip caused by a missing request apart from a turn that is dropped. Timed grants with presets 3 and 0 fix the grant length at preset+1 cycles, a long hold with the timer disabled shows that the enable is active low, and a stretch with every line requesting and grantDone pulsing checks that the grant is always one-hot.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam logic [3:0] NULL_CODE = 4'd2;

  typedef struct packed {
    logic advance;
    logic loadTimer;
  } arbStrobe_t;
endpackage

// File: rtl/slot_arb_dp.sv
module slot_arb_dp
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int CODE_W     = 4,
  parameter int REG_W      = 32,
  parameter int TMR_W      = 8,
  parameter int TMR_EN_BIT = 16,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [REG_W-1:0]  cfgWrData,
  input  arbStrobe_t        strobe,
  output logic [CODE_W-1:0] slotCode,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              timerExpired
);
  localparam int SLOTS_PER_REG = REG_W / CODE_W;
  localparam int NUM_TBL_REGS  = NUM_SLOTS / SLOTS_PER_REG;
  localparam int TMR_SEL       = NUM_TBL_REGS;

  logic [NUM_SLOTS*CODE_W-1:0] tblBits;
  logic [TMR_W-1:0]            tmrPreset;
  logic                        tmrDisable;
  logic [TMR_W-1:0]            tmrCount;
  logic [SLOT_W-1:0]           ptr;

  // Schedule storage: one packed word per configuration register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tblBits <= {NUM_SLOTS{CODE_W'(NULL_CODE)}};
    end else if (cfgWrEn) begin
      for (int r = 0; r < NUM_TBL_REGS; r++) begin
        if (cfgSel == 2'(r)) tblBits[r*REG_W +: REG_W] <= cfgWrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrPreset  <= '0;
      tmrDisable <= 1'b1;
    end else if (cfgWrEn && cfgSel == 2'(TMR_SEL)) begin
      tmrPreset  <= cfgWrData[TMR_W-1:0];
      tmrDisable <= cfgWrData[TMR_EN_BIT];
    end
  end

  // Countdown loaded at grant start, free-running down to zero
  always_ff @(posedge clk) begin
    if (!rstN)                  tmrCount <= '0;
    else if (strobe.loadTimer)  tmrCount <= tmrPreset;
    else if (tmrCount != '0)    tmrCount <= tmrCount - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               ptr <= '0;
    else if (strobe.advance) ptr <= ptr + 1'b1;
  end

  assign slotCode     = tblBits[ptr*CODE_W +: CODE_W];
  assign slotIdx      = ptr;
  assign timerExpired = !tmrDisable && (tmrCount == '0);
endmodule

// File: rtl/slot_arb_ctrl.sv
module slot_arb_ctrl
  import slot_arb_pkg::*;
#(
  parameter int NUM_REQ = 8,
  parameter int CODE_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REQ-1:0] reqIn,
  input  logic               grantDone,
  input  logic [CODE_W-1:0]  slotCode,
  input  logic               timerExpired,
  output arbStrobe_t         strobe,
  output logic [NUM_REQ-1:0] grantOut
);
  localparam int IDX_W = $clog2(NUM_REQ);

  logic               busy;
  logic               codeOk;
  logic               reqHit;
  logic [NUM_REQ-1:0] grantNext;

  assign busy   = |grantOut;
  assign codeOk = (int'(slotCode) < NUM_REQ) && (slotCode != CODE_W'(NULL_CODE));
  assign reqHit = codeOk && reqIn[slotCode[IDX_W-1:0]];

  always_comb begin
    strobe    = '0;
    grantNext = grantOut;
    if (!busy) begin
      if (reqHit) begin
        grantNext                        = '0;
        grantNext[slotCode[IDX_W-1:0]]   = 1'b1;
        strobe.loadTimer                 = 1'b1;
      end else begin
        strobe.advance = 1'b1;
      end
    end else if (grantDone || timerExpired) begin
      grantNext      = '0;
      strobe.advance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) grantOut <= '0;
    else       grantOut <= grantNext;
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NUM_SLOTS  = 16,
  parameter int NUM_REQ    = 8,
  parameter int CODE_W     = 4,
  parameter int REG_W      = 32,
  parameter int TMR_W      = 8,
  parameter int TMR_EN_BIT = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWrEn,
  input  logic [1:0]                   cfgSel,
  input  logic [REG_W-1:0]             cfgWrData,
  input  logic [NUM_REQ-1:0]           reqIn,
  input  logic                         grantDone,
  output logic [NUM_REQ-1:0]           grantOut,
  output logic [$clog2(NUM_SLOTS)-1:0] slotIdx
);
  arbStrobe_t        strobe;
  logic [CODE_W-1:0] slotCode;
  logic              timerExpired;

  slot_arb_dp #(
    .NUM_SLOTS(NUM_SLOTS), .CODE_W(CODE_W), .REG_W(REG_W),
    .TMR_W(TMR_W), .TMR_EN_BIT(TMR_EN_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .strobe(strobe), .slotCode(slotCode),
    .slotIdx(slotIdx), .timerExpired(timerExpired)
  );

  slot_arb_ctrl #(.NUM_REQ(NUM_REQ), .CODE_W(CODE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .grantDone(grantDone),
    .slotCode(slotCode), .timerExpired(timerExpired),
    .strobe(strobe), .grantOut(grantOut)
  );
endmodule

// File: rtl/slot_arb_chk.sv
module slot_arb_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_REQ   = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_REQ-1:0] reqIn,
  input logic               grantDone,
  input logic               timerExpired,
  input logic [NUM_REQ-1:0] grantOut,
  input logic [SLOT_W-1:0]  slotIdx
);
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOut));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0 && !grantDone && !timerExpired) |=> $stable(grantOut));

  // R4
  slot_parked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0 && !grantDone && !timerExpired) |=> $stable(slotIdx));

  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0 && grantDone) |=> (grantOut == '0));

  // R9
  done_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut != '0 && grantDone) |=> (slotIdx == SLOT_W'($past(slotIdx) + 1'b1)));

  // R4
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|grantOut) |-> (($past(reqIn) & grantOut) != '0));
endmodule

bind slot_arbiter slot_arb_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_REQ(NUM_REQ)) chk_i (
  .clk(clk), .rstN(rstN), .reqIn(reqIn), .grantDone(grantDone),
  .timerExpired(timerExpired), .grantOut(grantOut), .slotIdx(slotIdx)
);

// File: tb/slot_arbiter_tb.sv
module slot_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic [7:0]  reqIn = '0;
  logic        grantDone = 1'b0;
  logic [7:0]  grantOut;
  logic [3:0]  slotIdx;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  slot_arbiter dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .reqIn(reqIn), .grantDone(grantDone),
    .grantOut(grantOut), .slotIdx(slotIdx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  task automatic writeCfg(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitSlot(input logic [3:0] k);
    for (int g = 0; g < 40 && slotIdx !== k; g++) @(negedge clk);
  endtask

  task automatic pulseDone();
    grantDone = 1'b1;
    @(negedge clk);
    grantDone = 1'b0;
  endtask

  task automatic testReset();
    int seen;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", grantOut, 0);
    chk("R1 slot in reset", slotIdx, 0);
    rstN = 1'b1;
    chk("R1 slot after release", slotIdx, 0);
    reqIn = 8'hFF;
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (grantOut != 0) seen++;
    end
    chk("R1 idle table grants nobody", seen, 0);
    reqIn = 8'h00;
  endtask

  task automatic testBasicGrant();
    waitSlot(4'd3);
    reqIn = 8'h08;
    @(negedge clk);
    chk("R4 grant class 3", grantOut, 8'h08);
    chk("R4 slot held", slotIdx, 3);
    repeat (10) @(negedge clk);
    chk("R7 disabled timer holds grant", grantOut, 8'h08);
    chk("R6 slot still 3", slotIdx, 3);
    reqIn = 8'h00;
    pulseDone();
    chk("R6 grant cleared", grantOut, 0);
    chk("R6 slot advanced", slotIdx, 4);
  endtask

  task automatic testHighWord();
    waitSlot(4'd8);
    reqIn = 8'h10;
    @(negedge clk);
    chk("R2 high word turn 8", grantOut, 8'h10);
    chk("R2 slot 8", slotIdx, 8);
    reqIn = 8'h00;
    pulseDone();
    chk("R6 grant cleared after turn 8", grantOut, 0);
    chk("R6 slot 9", slotIdx, 9);
  endtask

  task automatic testSkipIdle();
    reqIn = 8'h00;
    waitSlot(4'd0);
    reqIn = 8'h02;
    @(negedge clk);
    chk("R5 non-requesting turn skipped", grantOut, 0);
    chk("R5 slot 1", slotIdx, 1);
    @(negedge clk);
    chk("R4 grant class 1", grantOut, 8'h02);
    reqIn = 8'h00;
    pulseDone();
    chk("R6 slot 2 after done", slotIdx, 2);
  endtask

  task automatic testNullReserved();
    reqIn = 8'h00;
    waitSlot(4'd9);
    reqIn = 8'hFF;
    @(negedge clk);
    chk("R3 code 8 grants nobody", grantOut, 0);
    chk("R3 slot 10", slotIdx, 10);
    @(negedge clk);
    chk("R3 code 15 grants nobody", grantOut, 0);
    chk("R3 slot 11", slotIdx, 11);
    reqIn = 8'h00;
    waitSlot(4'd2);
    reqIn = 8'hFF;
    @(negedge clk);
    chk("R3 idle code grants nobody", grantOut, 0);
    chk("R3 slot 3", slotIdx, 3);
    @(negedge clk);
    chk("R3 code 3 grants bit 3", grantOut, 8'h08);
    reqIn = 8'h00;
    pulseDone();
  endtask

  task automatic testTimeout();
    writeCfg(2'd2, 32'h0000_0003);
    reqIn = 8'h00;
    waitSlot(4'd5);
    reqIn = 8'h20;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 preset 3 grant held", grantOut, 8'h20);
    end
    @(negedge clk);
    chk("R7 timeout ends grant", grantOut, 0);
    chk("R7 slot after timeout", slotIdx, 6);
    reqIn = 8'h00;
    writeCfg(2'd2, 32'h0000_0000);
    waitSlot(4'd7);
    reqIn = 8'h80;
    @(negedge clk);
    chk("R7 preset 0 grant", grantOut, 8'h80);
    @(negedge clk);
    chk("R7 preset 0 one cycle", grantOut, 0);
    chk("R7 slot 8 after timeout", slotIdx, 8);
    reqIn = 8'h00;
    writeCfg(2'd2, 32'h0001_0000);
  endtask

  task automatic testWrap();
    reqIn = 8'h00;
    waitSlot(4'd15);
    grantDone = 1'b1;
    @(negedge clk);
    chk("R9 wrap to 0", slotIdx, 0);
    chk("R10 done while idle no grant", grantOut, 0);
    grantDone = 1'b0;
    @(negedge clk);
    chk("R10 single step", slotIdx, 1);
  endtask

  task automatic testOneHot();
    int bad;
    int grants;
    bad = 0;
    grants = 0;
    reqIn = 8'hFF;
    for (int i = 0; i < 60; i++) begin
      grantDone = (i % 3 == 0);
      @(negedge clk);
      if ($countones(grantOut) > 1) bad++;
      if (grantOut != 0) grants++;
    end
    chk("R8 one-hot grant", bad, 0);
    chk("R8 grants occurred", (grants > 0), 1);
    reqIn = 8'h00;
    pulseDone();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    testReset();
    writeCfg(2'd0, 32'h7654_3210);
    writeCfg(2'd1, 32'h2222_2F84);
    writeCfg(2'd2, 32'h0001_0005);
    writeCfg(2'd3, 32'h0000_0000);
    testBasicGrant();
    testHighWord();
    testSkipIdle();
    testNullReserved();
    testTimeout();
    testWrap();
    testOneHot();
    summary();
  end
endmodule